// File: doc/BRIEF.md
# Multi-width aliased floating-point register file

This block holds the floating-point operand state of a core. One storage array can be viewed three ways: as 32-bit single registers, as 64-bit double registers, or as 128-bit quad registers. The three views overlap. Two consecutive singles make up one double, and two consecutive doubles make up one quad. Every access carries a width code and an index counted in single-register units, so one index space names all three views.

The base bank holds 16 doubles, which are also 32 singles or 8 quads. When `EXT_EN` is set, a second bank of the same size sits above the base bank. That bank can be named only as doubles or quads. The block has one write port and `NUM_RD` combinational read ports. A read in the same cycle as a write to overlapping storage sees the new data. An index that does not fit the requested width raises an illegal flag. An illegal write leaves the storage untouched.

Top module: `fprf_alias`

## Requirements
- R1: After an asynchronous reset on `rst_ni`, every storage word is zero, so every legal read returns zero.
- R2: Width code 2'b00 selects single width. A legal single read at index i (0 to 31) returns word i in bits [31:0], with bits [127:32] zero. A single write takes its value from `wr_data_i[31:0]` only.
- R3: Width code 2'b01 selects double width, at an even index i. The double returns word i in bits [63:32] and word i+1 in bits [31:0], with bits [127:64] zero. A double write stores `wr_data_i[63:32]` into word i and `wr_data_i[31:0]` into word i+1.
- R4: Width code 2'b10 selects quad width, at an index i that is a multiple of 4. The quad returns words i, i+1, i+2 and i+3 in bits [127:96], [95:64], [63:32] and [31:0]. A quad write stores all four words in one cycle.
- R5: With the extended bank enabled, indices 32 to 63 are legal at double and quad width. A single-width access at any index of 32 or above is illegal.
- R6: The following accesses are illegal: width code 2'b11, an odd double index, a quad index that is not a multiple of 4, or an index beyond the implemented storage. A read port flags an illegal access in the same cycle on `rd_illegal_o` and returns all-zero data.
- R7: When `wr_en_i` is high and the access is illegal, `wr_illegal_o` is high in that cycle and no storage word changes. `wr_illegal_o` is low whenever `wr_en_i` is low.
- R8: A legal write changes only the words it covers. From the next cycle, a read at any width that overlaps those words returns the new values.
- R9: When a read overlaps a legal write in the same cycle, the overlapping words return the write data and the remaining words return the stored values.
- R10: Each read port has its own width code, index, data and illegal flag, and works independently of the other ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write request |
| wr_prec_i | input | 2 | Write width code (00 single, 01 double, 10 quad, 11 reserved) |
| wr_idx_i | input | IDX_W (6) | Write index in single-register units |
| wr_data_i | input | 128 | Write data, right-aligned to the access width |
| wr_illegal_o | output | 1 | Write request is illegal and was dropped |
| rd_prec_i | input | 2*NUM_RD | Width code per read port |
| rd_idx_i | input | IDX_W*NUM_RD | Index per read port |
| rd_data_o | output | 128*NUM_RD | Read data per port, right-aligned, upper bits zero |
| rd_illegal_o | output | NUM_RD | Illegal access flag per read port |

## Verification
The bench targets three kinds of fault. First, word ordering inside a double or quad: a design that swaps halves returns single data in the wrong slot. Second, single-width access to the extended bank and misaligned indices: a design with a loose legality decode either accepts these accesses or corrupts storage on a dropped write, and the bench catches this by rereading every double after a sweep of illegal writes. Third, same-cycle bypass with partial overlap: a design that bypasses the whole access instead of the overlapping words returns stale or foreign data in the other half.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned ACC_W  = WORD_W * LANES;

  typedef enum logic [1:0] {
    PREC_SGL = 2'b00,
    PREC_DBL = 2'b01,
    PREC_QAD = 2'b10,
    PREC_RSV = 2'b11
  } prec_e;

  function automatic logic [2:0] lanes_of(prec_e p);
    case (p)
      PREC_SGL: lanes_of = 3'd1;
      PREC_DBL: lanes_of = 3'd2;
      PREC_QAD: lanes_of = 3'd4;
      default:  lanes_of = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/fprf_legal.sv
module fprf_legal
  import fprf_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int BASE_WORDS = 32,
  parameter int NUM_WORDS  = 64
) (
  input  prec_e              prec_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               legal_o
);
  localparam logic [IDX_W:0] BW_L = (IDX_W+1)'(BASE_WORDS);
  localparam logic [IDX_W:0] NW_L = (IDX_W+1)'(NUM_WORDS);

  logic in_range;
  assign in_range = {1'b0, idx_i} < NW_L;

  always_comb begin
    case (prec_i)
      PREC_SGL: legal_o = {1'b0, idx_i} < BW_L;
      PREC_DBL: legal_o = in_range && !idx_i[0];
      PREC_QAD: legal_o = in_range && (idx_i[1:0] == 2'b00);
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fprf_wr_dec.sv
module fprf_wr_dec
  import fprf_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int NUM_WORDS = 64
) (
  input  logic                                  en_i,
  input  prec_e                                 prec_i,
  input  logic [IDX_W-1:0]                      idx_i,
  input  logic [ACC_W-1:0]                      data_i,
  output logic [NUM_WORDS-1:0]                  mask_o,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]      word_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [IDX_W-1:0] WI = IDX_W'(w);
    logic       hit;
    logic [1:0] slot;

    // slot counts 32-bit lanes from the LSB of the right-aligned data
    always_comb begin
      case (prec_i)
        PREC_SGL: begin hit = (idx_i == WI);                        slot = 2'd0; end
        PREC_DBL: begin hit = (idx_i[IDX_W-1:1] == WI[IDX_W-1:1]);  slot = {1'b0, ~WI[0]}; end
        PREC_QAD: begin hit = (idx_i[IDX_W-1:2] == WI[IDX_W-1:2]);  slot = ~WI[1:0]; end
        default:  begin hit = 1'b0;                                 slot = 2'd0; end
      endcase
    end

    assign mask_o[w] = en_i && hit;
    assign word_o[w] = data_i[{slot, 5'd0} +: WORD_W];
  end
endmodule

// File: rtl/fprf_rd_mux.sv
module fprf_rd_mux
  import fprf_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int NUM_WORDS = 64
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] view_i,
  input  prec_e                            prec_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic                             legal_i,
  output logic [ACC_W-1:0]                 data_o
);
  logic [2:0] n_lanes;
  assign n_lanes = lanes_of(prec_i);

  always_comb begin
    data_o = '0;
    if (legal_i) begin
      for (int j = 0; j < int'(LANES); j++) begin
        if (j < int'(n_lanes))
          data_o[WORD_W*(int'(n_lanes)-1-j) +: WORD_W] = view_i[idx_i + IDX_W'(j)];
      end
    end
  end
endmodule

// File: rtl/fprf_alias.sv
module fprf_alias
  import fprf_pkg::*;
#(
  parameter  int BASE_DBL = 16,
  parameter  bit EXT_EN   = 1'b1,
  parameter  int NUM_RD   = 2,
  localparam int IDX_W    = $clog2(4 * BASE_DBL)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_prec_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [127:0]             wr_data_i,
  output logic                     wr_illegal_o,
  input  logic [2*NUM_RD-1:0]      rd_prec_i,
  input  logic [IDX_W*NUM_RD-1:0]  rd_idx_i,
  output logic [128*NUM_RD-1:0]    rd_data_o,
  output logic [NUM_RD-1:0]        rd_illegal_o
);
  localparam int BASE_WORDS = 2 * BASE_DBL;
  localparam int NUM_WORDS  = EXT_EN ? 2 * BASE_WORDS : BASE_WORDS;

  prec_e                            wr_prec;
  logic                             wr_legal;
  logic                             wr_go;
  logic [NUM_WORDS-1:0]             wr_mask;
  logic [NUM_WORDS-1:0][WORD_W-1:0] wr_word;
  logic [NUM_WORDS-1:0][WORD_W-1:0] mem_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] view;

  assign wr_prec = prec_e'(wr_prec_i);

  fprf_legal #(.IDX_W(IDX_W), .BASE_WORDS(BASE_WORDS), .NUM_WORDS(NUM_WORDS)) i_wr_legal (
    .prec_i (wr_prec),
    .idx_i  (wr_idx_i),
    .legal_o(wr_legal)
  );

  assign wr_go        = wr_en_i && wr_legal;
  assign wr_illegal_o = wr_en_i && !wr_legal;

  fprf_wr_dec #(.IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) i_wr_dec (
    .en_i  (wr_go),
    .prec_i(wr_prec),
    .idx_i (wr_idx_i),
    .data_i(wr_data_i),
    .mask_o(wr_mask),
    .word_o(wr_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (wr_mask[w]) mem_q[w] <= wr_word[w];
    end
  end

  // same-cycle bypass, word granular
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_view
    assign view[w] = wr_mask[w] ? wr_word[w] : mem_q[w];
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    prec_e prec;
    logic  legal;
    assign prec = prec_e'(rd_prec_i[2*p +: 2]);

    fprf_legal #(.IDX_W(IDX_W), .BASE_WORDS(BASE_WORDS), .NUM_WORDS(NUM_WORDS)) i_legal (
      .prec_i (prec),
      .idx_i  (rd_idx_i[IDX_W*p +: IDX_W]),
      .legal_o(legal)
    );

    fprf_rd_mux #(.IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) i_mux (
      .view_i (view),
      .prec_i (prec),
      .idx_i  (rd_idx_i[IDX_W*p +: IDX_W]),
      .legal_i(legal),
      .data_o (rd_data_o[128*p +: 128])
    );

    assign rd_illegal_o[p] = !legal;
  end
endmodule

// File: rtl/fprf_alias_chk.sv
module fprf_alias_chk #(
  parameter  int BASE_DBL = 16,
  parameter  bit EXT_EN   = 1'b1,
  parameter  int NUM_RD   = 2,
  localparam int IDX_W    = $clog2(4 * BASE_DBL),
  localparam int BASE_WORDS = 2 * BASE_DBL,
  localparam int NUM_WORDS  = EXT_EN ? 2 * BASE_WORDS : BASE_WORDS
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_en_i,
  input logic [1:0]                   wr_prec_i,
  input logic [IDX_W-1:0]             wr_idx_i,
  input logic [127:0]                 wr_data_i,
  input logic                         wr_illegal_o,
  input logic [2*NUM_RD-1:0]          rd_prec_i,
  input logic [IDX_W*NUM_RD-1:0]      rd_idx_i,
  input logic [128*NUM_RD-1:0]        rd_data_o,
  input logic [NUM_RD-1:0]            rd_illegal_o,
  input logic [NUM_WORDS-1:0][31:0]   mem_q
);
  localparam logic [IDX_W:0] BW_L = (IDX_W+1)'(BASE_WORDS);

  function automatic logic [127:0] width_mask(logic [1:0] p);
    case (p)
      2'b00:   width_mask = {96'd0, {32{1'b1}}};
      2'b01:   width_mask = {64'd0, {64{1'b1}}};
      2'b10:   width_mask = {128{1'b1}};
      default: width_mask = '0;
    endcase
  endfunction

  logic wr_ok;
  assign wr_ok = wr_en_i && !wr_illegal_o;

  assert_illegal_write_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_illegal_o) |=> $stable(mem_q));

  assert_no_flag_without_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> !wr_illegal_o);

  assert_single_ext_rejected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_prec_i == 2'b00 && {1'b0, wr_idx_i} >= BW_L) |-> wr_illegal_o);

  assert_misaligned_rejected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_prec_i == 2'b11 || (wr_prec_i == 2'b01 && wr_idx_i[0]) ||
                 (wr_prec_i == 2'b10 && wr_idx_i[1:0] != 2'b00))) |-> wr_illegal_o);

  assert_quad_both_halves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_prec_i == 2'b10) |=>
      (mem_q[$past(wr_idx_i)] == $past(wr_data_i[127:96]) &&
       mem_q[$past(wr_idx_i) + IDX_W'(3)] == $past(wr_data_i[31:0])));

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    logic [1:0]       rp;
    logic [IDX_W-1:0] ri;
    logic [127:0]     rd;
    assign rp = rd_prec_i[2*p +: 2];
    assign ri = rd_idx_i[IDX_W*p +: IDX_W];
    assign rd = rd_data_o[128*p +: 128];

    assert_illegal_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_illegal_o[p] |-> (rd == '0));

    assert_bypass_exact_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && !rd_illegal_o[p] && rp == wr_prec_i && ri == wr_idx_i) |->
        (rd == (wr_data_i & width_mask(wr_prec_i))));

    assert_double_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && !rd_illegal_o[p] && rp == 2'b01) |->
        (rd[63:32] == mem_q[ri] && rd[31:0] == mem_q[ri + IDX_W'(1)] && rd[127:64] == '0));
  end
endmodule

bind fprf_alias fprf_alias_chk #(.BASE_DBL(BASE_DBL), .EXT_EN(EXT_EN), .NUM_RD(NUM_RD)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_prec_i   (wr_prec_i),
  .wr_idx_i    (wr_idx_i),
  .wr_data_i   (wr_data_i),
  .wr_illegal_o(wr_illegal_o),
  .rd_prec_i   (rd_prec_i),
  .rd_idx_i    (rd_idx_i),
  .rd_data_o   (rd_data_o),
  .rd_illegal_o(rd_illegal_o),
  .mem_q       (mem_q)
);

// File: tb/test_fprf_alias.sv
`timescale 1ns/1ps
module test_fprf_alias;
  localparam int IW = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_prec = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [127:0] wr_data = '0;
  logic         wr_ill;
  logic [3:0]   rd_prec = '0;
  logic [2*IW-1:0] rd_idx = '0;
  logic [255:0] rd_data;
  logic [1:0]   rd_ill;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0]  m [64];
  bit           pw_en = 1'b0;
  int           pw_prec, pw_idx;
  logic [127:0] pw_data;

  always #2 clk = ~clk;

  fprf_alias i_fprf_alias (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_prec_i(wr_prec), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .wr_illegal_o(wr_ill),
    .rd_prec_i(rd_prec), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_illegal_o(rd_ill)
  );

  function automatic int lanes(int p);
    return (p == 0) ? 1 : (p == 1) ? 2 : (p == 2) ? 4 : 0;
  endfunction

  function automatic bit legal(int p, int i);
    if (p == 0) return i < 32;
    if (p == 1) return (i % 2 == 0) && i < 64;
    if (p == 2) return (i % 4 == 0) && i < 64;
    return 1'b0;
  endfunction

  function automatic logic [31:0] word_at(int w);
    if (pw_en && legal(pw_prec, pw_idx) && w >= pw_idx && w < pw_idx + lanes(pw_prec))
      return pw_data[32*(lanes(pw_prec)-1-(w-pw_idx)) +: 32];
    return m[w];
  endfunction

  function automatic logic [127:0] exp_rd(int p, int i);
    logic [127:0] r = '0;
    if (!legal(p, i)) return r;
    for (int j = 0; j < lanes(p); j++) r[32*(lanes(p)-1-j) +: 32] = word_at(i + j);
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_port(int port, int p, int i, string req);
    chk(req, rd_data[128*port +: 128], exp_rd(p, i));
    chk(req, 128'(rd_ill[port]), 128'(!legal(p, i)));
  endtask

  task automatic rd(int port, int p, int i, string req);
    @(negedge clk);
    rd_prec[2*port +: 2] = 2'(p);
    rd_idx[IW*port +: IW] = IW'(i);
    #1;
    check_port(port, p, i, req);
  endtask

  task automatic wr(int p, int i, logic [127:0] d, string req);
    @(negedge clk);
    wr_en = 1'b1; wr_prec = 2'(p); wr_idx = IW'(i); wr_data = d;
    pw_en = 1'b1; pw_prec = p; pw_idx = i; pw_data = d;
    #1;
    chk(req, 128'(wr_ill), 128'(!legal(p, i)));
    @(posedge clk);
    #1;
    if (legal(p, i))
      for (int j = 0; j < lanes(p); j++) m[i + j] = d[32*(lanes(p)-1-j) +: 32];
    wr_en = 1'b0; pw_en = 1'b0;
  endtask

  function automatic logic [31:0] pat(int i, int salt);
    return {8'(salt), 8'(i), 8'(~i), 8'(i * 3 + salt)};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 64; w++) m[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all storage zero after reset
    for (int q = 0; q < 64; q += 4) rd(q % 2, 2, q, "R1");

    // R2: singles, data taken from low 32 bits only
    for (int i = 0; i < 32; i++) wr(0, i, {96'hFEED_0000_BEEF_0000_CAFE_0000, pat(i, 8'h51)}, "R7");
    for (int i = 0; i < 32; i++) rd(0, 0, i, "R2");
    // R3: doubles built from single pairs
    for (int i = 0; i < 32; i += 2) rd(1, 1, i, "R3");
    // R4: quads built from four singles
    for (int i = 0; i < 32; i += 4) rd(0, 2, i, "R4");

    // R5: extended bank via doubles, read as quads and doubles
    for (int i = 32; i < 64; i += 2) wr(1, i, {64'hAAAA_5555_AAAA_5555, pat(i, 8'h62), pat(i + 1, 8'h62)}, "R5");
    for (int i = 32; i < 64; i += 4) rd(0, 2, i, "R5");
    for (int i = 32; i < 64; i += 2) rd(1, 1, i, "R5");

    // R8: quad writes visible at single and double width
    wr(2, 4,  {pat(4, 8'h73), pat(5, 8'h73), pat(6, 8'h73), pat(7, 8'h73)}, "R8");
    wr(2, 40, {pat(40, 8'h74), pat(41, 8'h74), pat(42, 8'h74), pat(43, 8'h74)}, "R8");
    for (int i = 0; i < 12; i++) rd(0, 0, i, "R8");
    for (int i = 36; i < 48; i += 2) rd(1, 1, i, "R8");
    wr(0, 9, {96'd0, 32'h1357_9BDF}, "R8");
    rd(0, 1, 8, "R8");
    rd(1, 2, 8, "R8");

    // R5/R6: legality sweep on reads
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 64; i++)
        rd(i % 2, p, i, (p == 0 && i >= 32) ? "R5" : "R6");

    // R7: illegal writes dropped; storage reread at double width
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 64; i++)
        if (!legal(p, i)) wr(p, i, {128{1'b1}}, "R7");
    for (int i = 0; i < 64; i += 2) rd(i % 2, 1, i, "R7");

    // R9: same-cycle bypass, full and partial overlap
    @(negedge clk);
    wr_en = 1'b1; wr_prec = 2'd2; wr_idx = IW'(8);
    wr_data = {32'hC0DE_0008, 32'hC0DE_0009, 32'hC0DE_000A, 32'hC0DE_000B};
    pw_en = 1'b1; pw_prec = 2; pw_idx = 8; pw_data = wr_data;
    rd_prec = {2'd1, 2'd0}; rd_idx = {IW'(12), IW'(9)};
    #1;
    check_port(0, 0, 9, "R9");
    check_port(1, 1, 12, "R9");
    @(posedge clk); #1;
    for (int j = 0; j < 4; j++) m[8 + j] = pw_data[32*(3-j) +: 32];
    wr_en = 1'b0; pw_en = 1'b0;

    @(negedge clk);
    wr_en = 1'b1; wr_prec = 2'd1; wr_idx = IW'(22);
    wr_data = {64'd0, 32'hB0B0_0022, 32'hB0B0_0023};
    pw_en = 1'b1; pw_prec = 1; pw_idx = 22; pw_data = wr_data;
    rd_prec = {2'd1, 2'd2}; rd_idx = {IW'(22), IW'(20)};
    #1;
    check_port(0, 2, 20, "R9");
    check_port(1, 1, 22, "R9");
    @(posedge clk); #1;
    m[22] = 32'hB0B0_0022; m[23] = 32'hB0B0_0023;
    wr_en = 1'b0; pw_en = 1'b0;

    // R10: ports independent in one cycle, one legal one illegal
    @(negedge clk);
    rd_prec = {2'd0, 2'd2}; rd_idx = {IW'(63), IW'(20)};
    #1;
    check_port(0, 2, 20, "R10");
    check_port(1, 0, 63, "R10");
    @(negedge clk);
    rd_prec = {2'd2, 2'd0}; rd_idx = {IW'(44), IW'(3)};
    #1;
    check_port(0, 0, 3, "R10");
    check_port(1, 2, 44, "R10");

    done = 1'b1;
    report();
    $finish;
  end
endmodule